// File: doc/BRIEF.md
# Counted-Enable Interrupt Pending Aggregator

This block gathers a parameterised set of level-sensitive interrupt sources into one interrupt request for a CPU. Each source holds a stored level flag and an enable counter. A separate register block, not part of this design, sends single-cycle increment and decrement pulses for each source. A source counts as enabled only when its counter sits exactly at a required value fixed at elaboration. The required value is the number of mask or priority fields that must all grant the source, so any one of them can withdraw it. A source is pending when its stored level is high and it is enabled.

The block keeps a running count of pending sources. A two-state machine drives the CPU request from that count. In `REQ_IDLE` the request is low. The transition RAISE, taken when the next count is non-zero, leads to `REQ_ACTIVE`, where the request is high. The transition DROP, taken when the next count is zero, leads back. Every other case holds the current state. When the CPU acknowledges, the block returns the vector of the lowest-indexed pending source, unless the CPU's mask level is fully raised. There is no priority arbitration between sources. Source `i` has vector `VEC_BASE + i*VEC_STEP`.

Top module: `irq_pend_agg`

## Requirements
- R1: After reset, all enable counters, stored level flags and the pending count are zero, `irq` is low and `ack_valid` is low.
- R2: A source's stored level flag takes the value of `src_level[i]` at each rising clock edge. Holding the same level changes nothing.
- R3: Source `i` becomes pending at the edge where its stored level is high and its counter equals its required count. The required count is the CW-bit field `REQ_CNT[i*CW +: CW]`.
- R4: An increment pulse arriving while the counter already equals the required count is ignored. A decrement pulse arriving while the counter is zero is ignored. Simultaneous increment and decrement pulses leave the counter unchanged.
- R5: A decrement that takes the counter down from the required count removes the source from pending at that edge, even if its level stays high.
- R6: The pending count always equals the number of pending sources. `irq` goes high at the edge where the count leaves zero and goes low at the edge where it returns to zero. Both happen at the same edge as the source change that causes them.
- R7: While `ack` is high, `imask` is not 4'hF and at least one source is pending, `ack_valid` is high and `ack_vector` equals `VEC_BASE + i*VEC_STEP`, where `i` is the lowest-indexed pending source.
- R8: While `imask` equals 4'hF, `ack_valid` is low and `ack_vector` is zero.
- R9: While `ack` is low or no source is pending, `ack_valid` is low and `ack_vector` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | N_SRC | Level of each interrupt source |
| en_inc | input | N_SRC | Per-source enable increment pulse |
| en_dec | input | N_SRC | Per-source enable decrement pulse |
| imask | input | 4 | CPU interrupt mask level; 4'hF blocks the vector |
| ack | input | 1 | CPU acknowledge request |
| irq | output | 1 | Interrupt request to the CPU |
| ack_valid | output | 1 | Vector on `ack_vector` is valid |
| ack_vector | output | VW | Vector of the lowest-indexed pending source |

## Verification
The hardest situation to reach from the ports is one edge where several sources gain and lose pending status at once. In that situation the pending count moves by more than one, or crosses zero while other sources change. A second hard case is an increment that arrives exactly at the required count, where a wrong counter would overshoot and silently disable the source. Directed sequences first walk one source through overshoot, underflow, enable loss and lowest-index selection. A long random phase then toggles levels on all sources together, with increment pulses biased above decrements. This keeps counters crowding the required value and the pending count swinging between zero and several.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

    typedef enum logic [0:0] {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_e;

endpackage

// File: rtl/ipa_source.sv
module ipa_source #(
    parameter int CW = 2,
    parameter logic [CW-1:0] REQ = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic inc,
    input  logic dec,
    output logic asrt_q,
    output logic pend_q,
    output logic rise,
    output logic fall
);
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pend_d;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != REQ) begin
            cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        pend_d = level && (cnt_d == REQ);
        rise   = pend_d && !pend_q;
        fall   = !pend_d && pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            asrt_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            asrt_q <= level;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/ipa_pick.sv
module ipa_pick #(
    parameter int N_SRC = 8,
    parameter int VW = 12,
    parameter logic [VW-1:0] VEC_BASE = '0,
    parameter logic [VW-1:0] VEC_STEP = '0,
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [VW-1:0]    vec
);
    logic [IW-1:0] idx;

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
        vec = VEC_BASE + VW'(idx) * VEC_STEP;
    end
endmodule

// File: rtl/irq_pend_agg.sv
module irq_pend_agg #(
    parameter int N_SRC = 8,
    parameter int CW = 2,
    parameter int VW = 12,
    parameter logic [N_SRC*CW-1:0] REQ_CNT = 16'h9E79,
    parameter logic [VW-1:0] VEC_BASE = 12'h400,
    parameter logic [VW-1:0] VEC_STEP = 12'h020,
    localparam int PCW = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_level,
    input  logic [N_SRC-1:0] en_inc,
    input  logic [N_SRC-1:0] en_dec,
    input  logic [3:0]       imask,
    input  logic             ack,
    output logic             irq,
    output logic             ack_valid,
    output logic [VW-1:0]    ack_vector
);
    import ipa_pkg::*;

    logic [N_SRC-1:0] asrt_q, pend_q, rise, fall;
    logic [PCW-1:0]   pend_cnt_q, pend_cnt_d, n_rise, n_fall;
    logic             pick_any;
    logic [VW-1:0]    pick_vec;
    req_state_e       state_q, state_d;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        ipa_source #(
            .CW (CW),
            .REQ(REQ_CNT[g*CW +: CW])
        ) u_src (
            .clk   (clk),
            .rst_n (rst_n),
            .level (src_level[g]),
            .inc   (en_inc[g]),
            .dec   (en_dec[g]),
            .asrt_q(asrt_q[g]),
            .pend_q(pend_q[g]),
            .rise  (rise[g]),
            .fall  (fall[g])
        );
    end

    ipa_pick #(
        .N_SRC   (N_SRC),
        .VW      (VW),
        .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP)
    ) u_pick (
        .pend(pend_q),
        .any (pick_any),
        .vec (pick_vec)
    );

    always_comb begin
        n_rise = '0;
        n_fall = '0;
        for (int i = 0; i < N_SRC; i++) begin
            n_rise = n_rise + PCW'(rise[i]);
            n_fall = n_fall + PCW'(fall[i]);
        end
        pend_cnt_d = pend_cnt_q + n_rise - n_fall;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (pend_cnt_d != '0) state_d = REQ_ACTIVE;
            REQ_ACTIVE: if (pend_cnt_d == '0) state_d = REQ_IDLE;
            default:    state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= REQ_IDLE;
            pend_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            pend_cnt_q <= pend_cnt_d;
        end
    end

    always_comb begin
        irq        = (state_q == REQ_ACTIVE);
        ack_valid  = ack && pick_any && (imask != 4'hF);
        ack_vector = ack_valid ? pick_vec : '0;
    end
endmodule

// File: rtl/ipa_chk.sv
module ipa_chk #(
    parameter int N_SRC = 8,
    parameter int PCW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       imask,
    input logic             ack,
    input logic             irq,
    input logic             ack_valid,
    input logic [N_SRC-1:0] asrt_q,
    input logic [N_SRC-1:0] pend_q,
    input logic [PCW-1:0]   pend_cnt_q
);
    // R6
    cnt_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_cnt_q) == $countones(pend_q));

    // R6
    irq_tracks_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend_cnt_q != '0));

    // R3
    pend_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~asrt_q) == '0);

    // R8
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imask == 4'hF) |-> !ack_valid);

    // R9
    valid_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack && pend_q != '0));
endmodule

bind irq_pend_agg ipa_chk #(
    .N_SRC(N_SRC),
    .PCW  (PCW)
) u_ipa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imask     (imask),
    .ack       (ack),
    .irq       (irq),
    .ack_valid (ack_valid),
    .asrt_q    (asrt_q),
    .pend_q    (pend_q),
    .pend_cnt_q(pend_cnt_q)
);

// File: tb/test_irq_pend_agg.sv
`timescale 1ns/1ps
module test_irq_pend_agg;
    localparam int N = 8;
    localparam int VW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_level = '0, en_inc = '0, en_dec = '0;
    logic [3:0]    imask = 4'h0;
    logic          ack = 1'b0;
    logic          irq, ack_valid;
    logic [VW-1:0] ack_vector;

    int checks = 0, errors = 0;
    bit done = 0;
    int req[N] = '{1, 2, 3, 1, 2, 3, 1, 2};
    int m_cnt[N], m_pend[N];
    int m_total;

    always #4 clk = ~clk;

    irq_pend_agg #(
        .N_SRC(N), .CW(2), .VW(VW), .REQ_CNT(16'h9E79),
        .VEC_BASE(12'h400), .VEC_STEP(12'h020)
    ) i_irq_pend_agg (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .en_inc(en_inc),
        .en_dec(en_dec), .imask(imask), .ack(ack), .irq(irq),
        .ack_valid(ack_valid), .ack_vector(ack_vector)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        m_total = 0;
        for (int i = 0; i < N; i++) begin
            if (en_inc[i] && !en_dec[i] && m_cnt[i] != req[i]) m_cnt[i]++;
            else if (en_dec[i] && !en_inc[i] && m_cnt[i] != 0) m_cnt[i]--;
            m_pend[i] = (src_level[i] && m_cnt[i] == req[i]) ? 1 : 0;
            m_total += m_pend[i];
        end
    endtask

    task automatic compare();
        int low = -1;
        for (int i = N - 1; i >= 0; i--) if (m_pend[i] != 0) low = i;
        chk("R6 irq", int'(irq), (m_total != 0) ? 1 : 0);
        if (imask == 4'hF) begin
            chk("R8 valid", int'(ack_valid), 0);
            chk("R8 vector", int'(ack_vector), 0);
        end else if (!ack || low < 0) begin
            chk("R9 valid", int'(ack_valid), 0);
            chk("R9 vector", int'(ack_vector), 0);
        end else begin
            chk("R7 valid", int'(ack_valid), 1);
            chk("R7 vector", int'(ack_vector), 'h400 + low * 'h20);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic pulse(bit up, int i);
        if (up) en_inc[i] = 1'b1; else en_dec[i] = 1'b1;
        step();
        en_inc = '0;
        en_dec = '0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_pend[i] = 0; end
        m_total = 0;
        ack = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq", int'(irq), 0);
        chk("R1 valid", int'(ack_valid), 0);
        step();
        chk("R1 idle after release", int'(irq), 0);

        src_level[0] = 1'b1; step();
        chk("R3 level without enable", int'(irq), 0);
        pulse(1, 0);
        chk("R3 enabled source pends", int'(irq), 1);
        chk("R3 vector", int'(ack_vector), 'h400);
        pulse(1, 0);
        chk("R4 extra inc keeps pending", int'(irq), 1);
        pulse(0, 0);
        chk("R5 dec from required drops", int'(irq), 0);
        pulse(0, 0);
        pulse(1, 0);
        chk("R4 dec at zero ignored", int'(irq), 1);
        en_inc[0] = 1'b1; en_dec[0] = 1'b1; step(); en_inc = '0; en_dec = '0;
        chk("R4 inc with dec no change", int'(irq), 1);

        src_level[1] = 1'b1;
        pulse(1, 1); pulse(1, 1);
        chk("R7 lowest index wins", int'(ack_vector), 'h400);
        src_level[0] = 1'b0; step();
        chk("R2 level drop seen", int'(ack_vector), 'h420);
        imask = 4'hF; step();
        chk("R8 full mask", int'(ack_valid), 0);
        imask = 4'h3; ack = 1'b0; step();
        chk("R9 no ack", int'(ack_valid), 0);
        ack = 1'b1;
        src_level[1] = 1'b0; step();
        chk("R6 irq drops at zero", int'(irq), 0);

        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 5) == 0) src_level[i] = ~src_level[i];
                en_inc[i] = ($urandom_range(0, 4) == 0);
                en_dec[i] = ($urandom_range(0, 6) == 0);
            end
            ack = ($urandom_range(0, 3) != 0);
            imask = ($urandom_range(0, 4) == 0) ? 4'hF : 4'($urandom_range(0, 14));
            step();
        end
        en_inc = '0; en_dec = '0;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule